// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host request port and one 16-bit-wide extended-data-out DRAM. Each request carries a 20-bit word address, a write flag, 16 bits of write data and two byte-lane enables. The block turns it into the strobe sequence the memory expects. The word address reaches the memory over a 10-bit bus in two halves: first the row, with the row strobe, then the column, with the column strobes. Each byte lane has its own column strobe, so one access can touch the high byte, the low byte or both.

After an access the row stays open. A later request to the same row costs only a column cycle. A request to another row closes the open one, waits out the precharge time and opens the new row. Timing limits are given in nanoseconds and converted to controller clock cycles. These limits are row-to-column delay, column pulse width, column precharge, row precharge, full row cycle, page cycle and the longest time a row may stay open. Writes use early-write timing. Read data is captured after the column strobe has risen, which the extended data hold allows.

A separate refresh block owns the strobes while it asserts the grant input. The controller finishes any access in flight, closes the row, and then stays idle with every strobe high. A host-side close input closes the open row on demand.

Top module: `edo_page_ctrl`

States: `ST_IDLE` (row closed, strobes high), `ST_ACT` (row strobe low, row address out, row-to-column delay), `ST_COL` (column address and write enable set up, column strobes high), `ST_STROBE` (enabled column strobes low), `ST_HOLD` (column strobes high, column precharge, read capture on the last cycle), `ST_OPEN` (row open, waiting), `ST_PRE` (row strobe high, precharge and full row cycle). Transitions:
- IDLE→ACT: a pending or newly accepted request, with no grant.
- ACT→COL, COL→STROBE, STROBE→HOLD, HOLD→OPEN: each when its cycle count expires.
- OPEN→COL: a same-row request is accepted.
- OPEN→PRE: a different-row request is accepted, or close, grant or open-row time limit occurs.
- PRE→IDLE: precharge and full row cycle are both met.

## Requirements
- R1: During reset and right after it, the row strobe, both column strobes, write enable and output enable are high (1 = inactive). Data drive is off, rd_valid is low, and the block is idle with req_ready high.
- R2: The row address is req_addr[19:10] and is presented when the row strobe falls. The column address is req_addr[9:0] and is presented when a column strobe falls.
- R3: req_be[1] selects the high column strobe and data bits 15..8. req_be[0] selects the low column strobe and bits 7..0. Only the strobes of set enables fall, and a write changes only the enabled lanes.
- R4: Each read returns one single-cycle rd_valid pulse. On the enabled lanes, rd_data equals the last data written there (0 if never written), and reads return in request order.
- R5: A request to the open row reuses it with no new row strobe fall. Successive column strobe falls are at least the page cycle apart.
- R6: Before any row strobe fall, the row strobe has been high for at least the precharge count. Consecutive row strobe falls are at least the full row cycle apart.
- R7: A column strobe falls no sooner than the row-to-column count after the row strobe fell.
- R8: For writes, write enable is low from at least one cycle before the column strobe falls. The controller drives the data bus only while output enable is high.
- R9: When close_req is held, the open row is closed and the block returns to idle with the row strobe high.
- R10: While refresh_grant is high, no request is accepted (req_ready low). Any open row is closed, and once idle all strobes stay high. After the grant drops, the held request is served.
- R11: A row that has been open for the open-row limit is closed at its next return to the open state, even under continuous hits. The row strobe low time stays between the limit and the limit plus one column access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 = high byte |
| rd_valid | output | 1 | Read data strobe, one cycle |
| rd_data | output | 16 | Read data |
| close_req | input | 1 | Close the open row and go idle |
| refresh_grant | input | 1 | Refresh block owns the memory |
| ctrl_idle | output | 1 | No row open, strobes released |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from memory |

## Verification
The assertions assume the host never sets both byte enables low. They also assume a held request keeps its fields stable until accepted, and that refresh_grant is only raised by a block that waits for ctrl_idle. The stimulus uses enables from 1 to 3 only and holds each request unchanged until req_ready is seen. It raises the grant and close inputs as levels held across many cycles, and uses a memory model that presents read data on the column strobe fall and holds it until the next one.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_STROBE,
        ST_HOLD,
        ST_OPEN,
        ST_PRE
    } edo_state_t;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int edo_ns2cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int LIMIT_CYC = 2500,
    parameter int RC_CYC    = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic over_limit,
    output logic rc_met
);
    localparam int SAT = (LIMIT_CYC > RC_CYC) ? LIMIT_CYC : RC_CYC;
    localparam int W   = $clog2(SAT + 1);

    logic [W-1:0] age_q;
    logic         ras_prev_q;

    // age_q: cycles elapsed since the most recent row strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q      <= W'(SAT);
            ras_prev_q <= 1'b1;
        end else begin
            ras_prev_q <= ras_n;
            if (!ras_n && ras_prev_q) begin
                age_q <= W'(1);
            end else if (age_q != W'(SAT)) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign over_limit = !ras_n && !ras_prev_q && (age_q >= W'(LIMIT_CYC));
    assign rc_met     = (age_q >= W'(RC_CYC));
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_BITS      = 10,
    parameter int COL_BITS      = 10,
    parameter int LANE_W        = 8,
    parameter int CLK_NS        = 4,
    parameter int T_RC_NS       = 104,
    parameter int T_PC_NS       = 25,
    parameter int T_RP_NS       = 40,
    parameter int T_RCD_NS      = 14,
    parameter int T_CAS_NS      = 10,
    parameter int T_CP_NS       = 10,
    parameter int T_RAS_MAX_NS  = 10000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
    input  logic [2*LANE_W-1:0]          req_wdata,
    input  logic [1:0]                   req_be,
    output logic                         rd_valid,
    output logic [2*LANE_W-1:0]          rd_data,
    input  logic                         close_req,
    input  logic                         refresh_grant,
    output logic                         ctrl_idle,
    output logic                         dram_ras_n,
    output logic                         dram_ucas_n,
    output logic                         dram_lcas_n,
    output logic                         dram_we_n,
    output logic                         dram_oe_n,
    output logic [ROW_BITS-1:0]          dram_addr,
    output logic [2*LANE_W-1:0]          dram_dq_out,
    output logic                         dram_dq_oe,
    input  logic [2*LANE_W-1:0]          dram_dq_in
);
    localparam int LANES    = 2;
    localparam int DQ_W     = LANES * LANE_W;
    localparam int RC_CYC   = edo_ns2cyc(T_RC_NS, CLK_NS);
    localparam int PC_CYC   = edo_ns2cyc(T_PC_NS, CLK_NS);
    localparam int RP_CYC   = edo_ns2cyc(T_RP_NS, CLK_NS);
    localparam int RCD_CYC  = edo_ns2cyc(T_RCD_NS, CLK_NS);
    localparam int CAS_CYC  = edo_ns2cyc(T_CAS_NS, CLK_NS);
    localparam int CP_CYC   = edo_ns2cyc(T_CP_NS, CLK_NS);
    localparam int LIM_CYC  = edo_ns2cyc(T_RAS_MAX_NS, CLK_NS);
    // Column high time stretched so that a whole page loop meets the page cycle.
    localparam int HOLD_CYC = (CP_CYC > PC_CYC - CAS_CYC - 2) ? CP_CYC : (PC_CYC - CAS_CYC - 2);
    localparam int T_MAX1   = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
    localparam int T_MAX2   = (HOLD_CYC > RP_CYC) ? HOLD_CYC : RP_CYC;
    localparam int TMR_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int TW       = $clog2(TMR_MAX + 1);

    edo_state_t           state_q, state_d;
    logic                 tmr_load, tmr_done;
    logic [TW-1:0]        tmr_val;
    logic                 ras_over, rc_met;
    logic                 accept, row_hit;
    logic                 wr_q, pend_q;
    logic [ROW_BITS-1:0]  row_q;
    logic [COL_BITS-1:0]  col_q;
    logic [DQ_W-1:0]      wd_q;
    logic [LANES-1:0]     be_q;
    logic [LANES-1:0]     cas_n_w;

    edo_cycle_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_ras_window #(.LIMIT_CYC(LIM_CYC), .RC_CYC(RC_CYC)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (dram_ras_n),
        .over_limit (ras_over),
        .rc_met     (rc_met)
    );

    assign row_hit = (req_addr[ROW_BITS+COL_BITS-1:COL_BITS] == row_q);
    assign accept  = req_valid && req_ready;

    // Next-state and timer control.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (!refresh_grant && (pend_q || req_valid)) begin
                    state_d  = ST_ACT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RCD_CYC - 1);
                end
            end
            ST_ACT: begin
                if (tmr_done) begin
                    state_d = ST_COL;
                end
            end
            ST_COL: begin
                state_d  = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = TW'(CAS_CYC - 1);
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (refresh_grant || close_req || ras_over || (req_valid && !row_hit)) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RP_CYC - 1);
                end else if (req_valid) begin
                    state_d = ST_COL;
                end
            end
            ST_PRE: begin
                if (tmr_done && rc_met) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            pend_q   <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            wd_q     <= '0;
            be_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                wr_q  <= req_write;
                row_q <= req_addr[ROW_BITS+COL_BITS-1:COL_BITS];
                col_q <= req_addr[COL_BITS-1:0];
                wd_q  <= req_wdata;
                be_q  <= req_be;
            end
            if (accept && state_q == ST_OPEN && !row_hit) begin
                pend_q <= 1'b1;
            end else if (state_q == ST_IDLE && state_d == ST_ACT) begin
                pend_q <= 1'b0;
            end
            rd_valid <= 1'b0;
            if (state_q == ST_HOLD && tmr_done && !wr_q) begin
                rd_valid <= 1'b1;
                rd_data  <= dram_dq_in;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cas_n_w[g] = !((state_q == ST_STROBE) && be_q[g]);
    end
    assign dram_ucas_n = cas_n_w[1];
    assign dram_lcas_n = cas_n_w[0];

    // Moore outputs.
    always_comb begin
        dram_ras_n  = !(state_q inside {ST_ACT, ST_COL, ST_STROBE, ST_HOLD, ST_OPEN});
        dram_we_n   = !(wr_q && (state_q inside {ST_COL, ST_STROBE}));
        dram_oe_n   = !(!wr_q && (state_q inside {ST_STROBE, ST_HOLD}));
        dram_dq_oe  = wr_q && (state_q inside {ST_COL, ST_STROBE});
        dram_dq_out = wd_q;
        dram_addr   = (state_q inside {ST_COL, ST_STROBE, ST_HOLD}) ? ROW_BITS'(col_q) : row_q;
        ctrl_idle   = (state_q == ST_IDLE);
        req_ready   = !refresh_grant &&
                      (((state_q == ST_IDLE) && !pend_q) ||
                       ((state_q == ST_OPEN) && !close_req && !ras_over));
    end
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
    parameter int RP_CYC  = 10,
    parameter int PC_CYC  = 7,
    parameter int RCD_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic close_req,
    input logic refresh_grant,
    input logic ctrl_idle,
    input logic dram_ras_n,
    input logic dram_ucas_n,
    input logic dram_lcas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    localparam int SAT = RP_CYC + PC_CYC + RCD_CYC;

    int   hi_run, cas_gap, ras_age;
    logic ras_prev, cas_prev;
    logic cas_low, cas_fall, ras_fall;

    assign cas_low  = !dram_ucas_n || !dram_lcas_n;
    assign cas_fall = cas_low && !cas_prev;
    assign ras_fall = !dram_ras_n && ras_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run   <= SAT;
            cas_gap  <= SAT;
            ras_age  <= SAT;
            ras_prev <= 1'b1;
            cas_prev <= 1'b0;
        end else begin
            ras_prev <= dram_ras_n;
            cas_prev <= cas_low;
            hi_run   <= dram_ras_n ? ((hi_run < SAT) ? hi_run + 1 : SAT) : 0;
            cas_gap  <= cas_fall ? 1 : ((cas_gap < SAT) ? cas_gap + 1 : SAT);
            ras_age  <= ras_fall ? 1 : ((ras_age < SAT) ? ras_age + 1 : SAT);
        end
    end

    // R3: column strobes only inside an open row
    a_r3_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        cas_low |-> !dram_ras_n);
    // R6: precharge honoured before every row open
    a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall |-> (hi_run >= RP_CYC));
    // R5: page cycle between column strobe falls
    a_r5_page_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall |-> (cas_gap >= PC_CYC));
    // R7: row-to-column delay
    a_r7_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall |-> (ras_age >= RCD_CYC));
    // R8: early write, write enable set up before the strobe
    a_r8_early_we: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && !dram_we_n) |-> !$past(dram_we_n));
    // R8: bus driven only with memory outputs disabled
    a_r8_bus_turn: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);
    // R10: no acceptance under grant
    a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_grant |-> !req_ready);
    // R10: strobes released while granted and idle
    a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_grant && ctrl_idle) |-> (dram_ras_n && !cas_low));
    // R9: idle under close means row closed
    a_r9_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (close_req && ctrl_idle) |-> dram_ras_n);
    // R4: read strobe is a single-cycle pulse
    a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
    .RP_CYC  (RP_CYC),
    .PC_CYC  (PC_CYC),
    .RCD_CYC (RCD_CYC)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rd_valid      (rd_valid),
    .close_req     (close_req),
    .refresh_grant (refresh_grant),
    .ctrl_idle     (ctrl_idle),
    .dram_ras_n    (dram_ras_n),
    .dram_ucas_n   (dram_ucas_n),
    .dram_lcas_n   (dram_lcas_n),
    .dram_we_n     (dram_we_n),
    .dram_oe_n     (dram_oe_n),
    .dram_dq_oe    (dram_dq_oe)
);

// File: tb/test_edo_page_ctrl.sv
`timescale 1ns/1ps
module test_edo_page_ctrl;
    localparam int CLK_NS   = 4;
    localparam int RAS_MAX  = 400;
    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int RP_C   = cyc(40);
    localparam int RC_C   = cyc(104);
    localparam int PC_C   = cyc(25);
    localparam int RCD_C  = cyc(14);
    localparam int CAS_C  = cyc(10);
    localparam int CP_C   = cyc(10);
    localparam int HOLD_C = (CP_C > PC_C - CAS_C - 2) ? CP_C : (PC_C - CAS_C - 2);
    localparam int LIM_C  = cyc(RAS_MAX);

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, close_req = 0, refresh_grant = 0;
    logic [19:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic [1:0]  req_be = 0;
    logic        req_ready, rd_valid, ctrl_idle;
    logic [15:0] rd_data, dram_dq_out;
    logic [15:0] dram_dq_in = 0;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;

    always #2 clk = ~clk;

    edo_page_ctrl #(.CLK_NS(CLK_NS), .T_RAS_MAX_NS(RAS_MAX)) i_edo_page_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .close_req(close_req),
        .refresh_grant(refresh_grant), .ctrl_idle(ctrl_idle), .dram_ras_n(dram_ras_n),
        .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_run = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction
    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return (old & ~lane_mask(be)) | (nw & lane_mask(be));
    endfunction

    // Memory model and timing observer, sampled mid-cycle.
    logic [15:0] dmem [int];
    logic [15:0] smem [int];
    logic        pr_ras = 1, pr_u = 1, pr_l = 1, pr_we = 1;
    int          hi_run = 1000, since_ras = 1000, since_cas = 1000;
    int          ras_falls = 0, u_falls = 0, l_falls = 0, low_run = 0, max_low = 0;
    logic [9:0]  lat_row = 0, lat_col = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit uf = pr_u && !dram_ucas_n;
            automatic bit lf = pr_l && !dram_lcas_n;
            automatic int w;
            if (pr_ras && !dram_ras_n) begin
                ras_falls++;
                chk(hi_run >= RP_C, "R6", "row precharge cycles", hi_run, RP_C);
                chk(since_ras >= RC_C, "R6", "row cycle", since_ras, RC_C);
                lat_row   = dram_addr;
                since_ras = 0;
            end
            if (uf || lf) begin
                lat_col = dram_addr;
                chk(since_ras >= RCD_C, "R7", "row-to-column", since_ras, RCD_C);
                chk(since_cas >= PC_C, "R5", "page cycle", since_cas, PC_C);
                since_cas = 0;
                if (uf) u_falls++;
                if (lf) l_falls++;
                w = int'({lat_row, lat_col});
                if (!dram_we_n) begin
                    chk(!pr_we, "R8", "WE early", pr_we, 0);
                    chk(dram_dq_oe && dram_oe_n, "R8", "drive with OE high",
                        {dram_dq_oe, dram_oe_n}, 2'b11);
                    if (!dmem.exists(w)) dmem[w] = 16'h0;
                    dmem[w] = merge(dmem[w], dram_dq_out, {uf, lf});
                end else begin
                    dram_dq_in <= dmem.exists(w) ? dmem[w] : 16'h0;
                end
            end
            hi_run  = dram_ras_n ? hi_run + 1 : 0;
            low_run = dram_ras_n ? 0 : low_run + 1;
            if (low_run > max_low) max_low = low_run;
            since_ras++;
            since_cas++;
            pr_ras = dram_ras_n; pr_u = dram_ucas_n; pr_l = dram_lcas_n; pr_we = dram_we_n;
        end
    end

    // Read checker against the bench's own shadow memory.
    logic [15:0] exp_d [$];
    logic [1:0]  exp_be [$];
    logic [15:0] last_rd = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            last_rd = rd_data;
            if (exp_d.size() == 0) begin
                chk(0, "R4", "unexpected rd_valid", 1, 0);
            end else begin
                automatic logic [15:0] e = exp_d.pop_front();
                automatic logic [15:0] m = lane_mask(exp_be.pop_front());
                chk((rd_data & m) == (e & m), "R4", "read data", rd_data & m, e & m);
            end
        end
    end

    int accepted = 0;
    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int k;
        k = int'(a);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        if (!smem.exists(k)) smem[k] = 16'h0;
        if (wr) begin
            smem[k] = merge(smem[k], d, be);
        end else begin
            exp_d.push_back(smem[k]);
            exp_be.push_back(be);
        end
        @(posedge clk);
        #1;
        req_valid = 0;
        accepted++;
    endtask

    task automatic drain;
        for (int i = 0; i < 400 && exp_d.size() != 0; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic close_row(output int took);
        took = 0;
        @(negedge clk);
        close_req = 1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            took++;
            if (ctrl_idle && dram_ras_n) break;
        end
        close_req = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int snap, snap_u, snap_l, took;
        logic [19:0] a;
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        // R1: quiet outputs during reset
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1F, "R1",
            "strobes in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1F);
        chk(!dram_dq_oe && !rd_valid, "R1", "drive/valid in reset", {dram_dq_oe, rd_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && ctrl_idle && dram_ras_n, "R1", "idle after reset",
            {req_ready, ctrl_idle, dram_ras_n}, 3'b111);

        // R2: address halves
        a = 20'hA53C7;
        do_req(1, a, 16'h1234, 2'b11);
        repeat (12) @(negedge clk);
        chk(lat_row == a[19:10], "R2", "row half", lat_row, a[19:10]);
        chk(lat_col == a[9:0], "R2", "column half", lat_col, a[9:0]);

        // R3: byte lanes
        snap_u = u_falls; snap_l = l_falls;
        do_req(1, a, 16'hAB99, 2'b10);
        repeat (12) @(negedge clk);
        chk(u_falls - snap_u == 1 && l_falls == snap_l, "R3", "high-lane strobes",
            {u_falls - snap_u, l_falls - snap_l}, 2'b10);
        snap_u = u_falls; snap_l = l_falls;
        do_req(1, a + 1, 16'h55CD, 2'b01);
        repeat (12) @(negedge clk);
        chk(u_falls == snap_u && l_falls - snap_l == 1, "R3", "low-lane strobes",
            {u_falls - snap_u, l_falls - snap_l}, 2'b01);
        do_req(0, a, 16'h0, 2'b11);
        drain();
        chk(last_rd == 16'hAB34, "R3", "lane merge", last_rd, 16'hAB34);

        // R5: hits reuse the open row
        close_row(took);
        snap = ras_falls;
        for (int i = 0; i < 4; i++) do_req(0, {10'h055, 10'(i * 3)}, 16'h0, 2'b11);
        drain();
        chk(ras_falls - snap == 1, "R5", "row opens for page hits", ras_falls - snap, 1);

        // R6: miss closes and reopens
        snap = ras_falls;
        do_req(0, {10'h1F0, 10'h00A}, 16'h0, 2'b01);
        drain();
        chk(ras_falls - snap == 1, "R6", "miss opens new row", ras_falls - snap, 1);
        chk(lat_row == 10'h1F0, "R6", "new row latched", lat_row, 10'h1F0);

        // R9: close on demand
        close_row(took);
        chk(ctrl_idle && dram_ras_n, "R9", "closed and idle", {ctrl_idle, dram_ras_n}, 2'b11);

        // R10: refresh grant
        do_req(1, {10'h2AA, 10'h3FF}, 16'hC3A5, 2'b11);
        @(negedge clk);
        refresh_grant = 1;
        snap = accepted;
        fork
            do_req(0, {10'h2AA, 10'h3FF}, 16'h0, 2'b11);
        join_none
        repeat (60) @(negedge clk);
        chk(accepted == snap, "R10", "no accept under grant", accepted - snap, 0);
        chk(ctrl_idle && dram_ras_n && dram_ucas_n && dram_lcas_n, "R10", "released",
            {ctrl_idle, dram_ras_n, dram_ucas_n, dram_lcas_n}, 4'hF);
        chk(!req_ready, "R10", "ready low", req_ready, 0);
        refresh_grant = 0;
        for (int i = 0; i < 100 && accepted == snap; i++) @(negedge clk);
        chk(accepted == snap + 1, "R10", "served after grant", accepted - snap, 1);
        drain();

        // R11: open-row limit under continuous hits
        close_row(took);
        snap = ras_falls;
        max_low = 0;
        for (int i = 0; i < 20; i++) do_req(1, {10'h077, 10'(i)}, 16'(i * 7), 2'b11);
        close_row(took);
        chk(ras_falls - snap >= 2, "R11", "row reopened", ras_falls - snap, 2);
        chk(max_low >= LIM_C, "R11", "low time floor", max_low, LIM_C);
        chk(max_low <= LIM_C + CAS_C + HOLD_C + 2, "R11", "low time ceiling",
            max_low, LIM_C + CAS_C + HOLD_C + 2);

        // Random mix over a few rows (R4 on every read)
        for (int i = 0; i < 400; i++) begin
            automatic logic [9:0] r = 10'(($urandom % 3) * 10'h111);
            automatic logic [9:0] c = 10'($urandom % 16);
            automatic logic [1:0] be = 2'($urandom % 3 + 1);
            do_req(1'($urandom), {r, c}, 16'($urandom), be);
            if ($urandom % 8 == 0) repeat ($urandom % 4) @(negedge clk);
        end
        drain();
        chk(exp_d.size() == 0, "R4", "all reads returned", exp_d.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule